// File: doc/BRIEF.md
# Packet CRC-16 Generator and Checker

This block computes the 16-bit packet CRC for a serial link whose datapath carries one 64-bit word per clock. Each word holds four 16-bit half-words. The half-word in the upper bits of a word comes first in the packet. A start marker selects the first word of a packet and an end marker selects the last. On the last word a four-bit mask tells which half-words are real.

The first six bits of every packet carry a per-link acknowledge number and a reserved bit. The CRC treats those six bits as zero. A switch can therefore renumber a packet on each hop and keep the CRC it already has.

The block runs in one of two modes. In generate mode the CRC value output at end of packet is the code that the transmit side appends after the last valid half-word. In check mode the last valid half-word is taken as the received CRC. That half-word is left out of the calculation and compared with the computed value. A mismatch raises an error flag for one cycle, together with the end-of-packet output.

Top module: `pkt_crc16`

## Requirements
- R1: The CRC uses the generator polynomial x^16+x^12+x^5+1 (0x1021). Bits are folded most-significant first. Within a word, half-word [63:48] is folded first, then [47:32], then [31:16], then [15:0].
- R2: The computation restarts from 0xFFFF on every word that has start-of-packet set. This holds even when the previous packet ended in the cycle just before.
- R3: Bits [63:58] of the start-of-packet word are folded as zeros, whatever their value.
- R4: Every half-word of a word without end-of-packet is folded, and the mask is ignored on such words. On the end word, a half-word is folded only when its mask bit is set. Mask bit 3 marks [63:48] and bit 0 marks [15:0]. Set bits are contiguous from bit 3.
- R5: In generate mode, `crc_value` after the end word equals the CRC over all valid half-words, with no inversion applied. `crc_err` stays low in this mode.
- R6: In check mode, the last valid half-word of the end word is the received CRC and is not folded. `crc_err` is high for exactly the one cycle in which `out_eop` is high, and only when the computed CRC differs from the received one.
- R7: `out_valid` and `out_eop` repeat `in_valid` and `in_valid && in_eop` one clock later. `crc_value` then shows the running CRC after the word just accepted.
- R8: While reset is asserted, `out_valid`, `out_eop` and `crc_err` are 0 and `crc_value` is 0xFFFF.
- R9: `crc_value` holds its value through cycles in which `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| check_mode | input | 1 | 0 = generate, 1 = check |
| in_valid | input | 1 | Word on `in_data` is valid |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | 64 | Packet word; [63:48] comes first |
| in_hmask | input | 4 | Valid half-words of the end word; bit 3 marks [63:48] |
| out_valid | output | 1 | A word was accepted in the previous cycle |
| out_eop | output | 1 | The accepted word ended a packet |
| crc_value | output | 16 | Running or final CRC |
| crc_err | output | 1 | Check-mode CRC mismatch at end of packet |

## Verification
The assertions take four things for granted about the inputs. A start marker lasts one cycle except on single-word packets. The end-word mask is non-empty and filled from bit 3 downward. A packet checked in check mode holds at least one half-word of payload in front of its CRC. The mode does not change inside a packet.

The bench builds each packet as a list of half-words and derives the mask from the list length, so every mask it sends has this form. It sets the mode only between packets and gives every check-mode packet at least one payload half-word. It also puts random data in the unused lanes and random masks on non-end words, so that these values can be seen to have no effect.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;
   localparam logic [15:0] CRC16_POLY_DEF = 16'h1021;
   localparam logic [15:0] CRC16_SEED_DEF = 16'hFFFF;

   typedef enum logic {
      CRC_MODE_GEN = 1'b0,
      CRC_MODE_CHK = 1'b1
   } crc_mode_e;
endpackage

// File: rtl/crc_lane_fold.sv
// Folds one lane of W bits, MSB first, into the running CRC; bypasses when en is low.
module crc_lane_fold #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    POLY = 16'h1021
) (
   input  logic [W-1:0] crc_in,
   input  logic [W-1:0] lane,
   input  logic         en,
   output logic [W-1:0] crc_out
);
   logic [W-1:0] acc;
   logic         fb;

   always_comb begin
      acc = crc_in;
      fb  = 1'b0;
      for (int b = W - 1; b >= 0; b--) begin
         fb  = acc[W-1] ^ lane[b];
         acc = {acc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      crc_out = en ? acc : crc_in;
   end
endmodule

// File: rtl/crc_lane_plan.sv
// Decides which lanes are folded and which lane carries the received CRC.
// Native mask indexing: bit LANES-1 is the first lane of the word.
module crc_lane_plan #(
   parameter int LANES = 4
) (
   input  logic             eop,
   input  logic             check,
   input  logic [LANES-1:0] hmask,
   output logic [LANES-1:0] fold_en,
   output logic [LANES-1:0] crc_sel
);
   localparam logic [LANES-1:0] ONE = {{(LANES-1){1'b0}}, 1'b1};

   logic [LANES-1:0] last_lane;

   always_comb begin
      last_lane = hmask & (~hmask + ONE);
      if (eop) begin
         crc_sel = check ? last_lane : '0;
         fold_en = hmask & ~crc_sel;
      end else begin
         crc_sel = '0;
         fold_en = '1;
      end
   end
endmodule

// File: rtl/pkt_crc16.sv
module pkt_crc16 #(
   parameter int               DATA_W    = 64,
   parameter int               LANE_W    = 16,
   parameter int               ZERO_LEAD = 6,
   parameter logic [LANE_W-1:0] POLY     = pkt_crc_pkg::CRC16_POLY_DEF,
   parameter logic [LANE_W-1:0] SEED     = pkt_crc_pkg::CRC16_SEED_DEF
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       check_mode,
   input  logic                       in_valid,
   input  logic                       in_sop,
   input  logic                       in_eop,
   input  logic [DATA_W-1:0]          in_data,
   input  logic [DATA_W/LANE_W-1:0]   in_hmask,
   output logic                       out_valid,
   output logic                       out_eop,
   output logic [LANE_W-1:0]          crc_value,
   output logic                       crc_err
);
   import pkt_crc_pkg::*;

   localparam int LANES = DATA_W / LANE_W;
   localparam logic [LANES-1:0] ONE_L = {{(LANES-1){1'b0}}, 1'b1};

   // elaboration-time parameter checks
   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("at least two lanes are required");
   end
   if (ZERO_LEAD < 0 || ZERO_LEAD >= LANE_W) begin : g_bad_lead
      $error("ZERO_LEAD must lie in [0, LANE_W)");
   end

   crc_mode_e mode;
   assign mode = crc_mode_e'(check_mode);

   logic [LANE_W-1:0] crc_q;
   logic [LANES-1:0]  fold_en;
   logic [LANES-1:0]  crc_sel;
   logic [LANE_W-1:0] rx_crc;
   logic [LANE_W-1:0] chain [LANES+1];

   crc_lane_plan #(.LANES(LANES)) u_plan (
      .eop     (in_eop),
      .check   (mode == CRC_MODE_CHK),
      .hmask   (in_hmask),
      .fold_en (fold_en),
      .crc_sel (crc_sel)
   );

   assign chain[0] = in_sop ? SEED : crc_q;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LANE_W-1:0] raw;
      logic [LANE_W-1:0] eff;
      assign raw = in_data[DATA_W-1-j*LANE_W -: LANE_W];
      if (j == 0 && ZERO_LEAD > 0) begin : g_lead
         localparam logic [LANE_W-1:0] KEEP = {LANE_W{1'b1}} >> ZERO_LEAD;
         assign eff = in_sop ? (raw & KEEP) : raw;
      end else begin : g_plain
         assign eff = raw;
      end
      crc_lane_fold #(.W(LANE_W), .POLY(POLY)) u_fold (
         .crc_in  (chain[j]),
         .lane    (eff),
         .en      (fold_en[LANES-1-j]),
         .crc_out (chain[j+1])
      );
   end

   always_comb begin
      rx_crc = '0;
      for (int j = 0; j < LANES; j++) begin
         if (crc_sel[LANES-1-j]) rx_crc = rx_crc | in_data[DATA_W-1-j*LANE_W -: LANE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q     <= SEED;
         out_valid <= 1'b0;
         out_eop   <= 1'b0;
         crc_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_eop   <= in_valid && in_eop;
         crc_err   <= in_valid && in_eop && (mode == CRC_MODE_CHK) && (chain[LANES] != rx_crc);
         if (in_valid) crc_q <= chain[LANES];
      end
   end

   assign crc_value = crc_q;

   // R6: error only with the end-of-packet output
   p_err_with_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> out_eop);
   // R5: no error in generate mode
   p_gen_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!check_mode) |-> !crc_err);
   // R7: one-cycle latency of the valid flag
   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_eop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |-> out_valid);
   // R9: value holds across idle cycles
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(crc_value));
   // R4: end-word mask is non-empty and filled from the top lane down
   p_mask_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eop) |-> (in_hmask != '0 && ((~in_hmask & (~in_hmask + ONE_L)) == '0)));
   // R2: a start marker on a multi-word packet lasts one cycle
   p_sop_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && !in_eop) |=> !(in_valid && in_sop));
endmodule

// File: tb/tb_pkt_crc16.sv
`timescale 1ns/1ps
module tb_pkt_crc16;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        check_mode;
   logic        in_valid, in_sop, in_eop;
   logic [63:0] in_data;
   logic [3:0]  in_hmask;
   logic        out_valid, out_eop, crc_err;
   logic [15:0] crc_value;

   int total = 0;
   int bad   = 0;
   bit finished = 0;
   logic [15:0] m_crc;   // model's view of crc_value

   always #4 clk = ~clk;

   pkt_crc16 dut (
      .clk(clk), .rst_n(rst_n), .check_mode(check_mode),
      .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_data(in_data), .in_hmask(in_hmask),
      .out_valid(out_valid), .out_eop(out_eop),
      .crc_value(crc_value), .crc_err(crc_err)
   );

   function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [15:0] hw);
      logic [15:0] r = c;
      for (int b = 15; b >= 0; b--) begin
         if (r[15] ^ hw[b]) r = (r << 1) ^ 16'h1021;
         else               r = r << 1;
      end
      return r;
   endfunction

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic idle(input string tag);
      in_valid = 1'b0; in_sop = $urandom; in_eop = $urandom;
      in_data = {$urandom, $urandom}; in_hmask = $urandom;
      @(negedge clk);
      chk("R7", "out_valid idle", {15'd0, out_valid}, 16'd0);
      chk("R7", "out_eop idle", {15'd0, out_eop}, 16'd0);
      chk(tag, "crc_err idle", {15'd0, crc_err}, 16'd0);
      chk("R9", "crc_value hold", crc_value, m_crc);
   endtask

   // chk_mode: check mode; nhw: payload half-words; corrupt: damage appended CRC
   task automatic run_packet(input bit chk_mode, input int nhw, input bit corrupt,
                             input bit gaps, input string tag);
      logic [15:0] hw[$];
      logic [15:0] c;
      int len, nwords, cnt;
      hw.delete();
      for (int i = 0; i < nhw; i++) hw.push_back(16'($urandom));
      if (chk_mode) begin
         c = 16'hFFFF;
         for (int i = 0; i < nhw; i++) c = ref_fold(c, (i == 0) ? (hw[i] & 16'h03FF) : hw[i]);
         hw.push_back(corrupt ? (c ^ 16'h0100) : c);
      end
      len = hw.size();
      nwords = (len + 3) / 4;
      check_mode = chk_mode;
      for (int w = 0; w < nwords; w++) begin
         logic [63:0] d;
         logic [3:0]  mk;
         bit last, e_err;
         last = (w == nwords - 1);
         d = {$urandom, $urandom};
         if (w == 0) m_crc = 16'hFFFF;
         for (int k = 0; k < 4; k++) begin
            int idx = 4 * w + k;
            if (idx < len) begin
               d[63-16*k -: 16] = hw[idx];
               if (!(chk_mode && idx == len - 1))
                  m_crc = ref_fold(m_crc, (idx == 0) ? (hw[idx] & 16'h03FF) : hw[idx]);
            end
         end
         if (last) begin
            cnt = len - 4 * w;
            mk = 4'hF << (4 - cnt);
         end else begin
            mk = 4'($urandom);
         end
         e_err = chk_mode && last && (m_crc != hw[len-1]);
         in_valid = 1'b1; in_sop = (w == 0); in_eop = last;
         in_data = d; in_hmask = mk;
         @(negedge clk);
         chk("R7", "out_valid", {15'd0, out_valid}, 16'd1);
         chk("R7", "out_eop", {15'd0, out_eop}, {15'd0, last});
         chk(tag, "crc_value", crc_value, m_crc);
         chk(chk_mode ? "R6" : "R5", "crc_err", {15'd0, crc_err}, {15'd0, e_err});
         if (gaps && !last && ($urandom % 2 == 1)) idle("R9");
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8", "reset out_valid", {15'd0, out_valid}, 16'd0);
      chk("R8", "reset out_eop", {15'd0, out_eop}, 16'd0);
      chk("R8", "reset crc_err", {15'd0, crc_err}, 16'd0);
      chk("R8", "reset crc_value", crc_value, 16'hFFFF);
      m_crc = 16'hFFFF;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "after reset crc_value", crc_value, 16'hFFFF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; check_mode = 1'b0;
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      in_data = '0; in_hmask = '0; m_crc = 16'hFFFF;
      @(negedge clk);
      do_reset();

      // R1: a single full word, then multi-word packets
      run_packet(0, 4, 0, 0, "R1");
      run_packet(0, 9, 0, 0, "R1");
      idle("R9");
      // R4: every end-word mask width, with random masks on inner words
      for (int n = 1; n <= 12; n++) run_packet(0, n, 0, 1, "R4");
      // R2: back-to-back packets restart from the seed
      for (int i = 0; i < 10; i++) run_packet(0, 1 + ($urandom % 10), 0, 0, "R2");
      for (int i = 0; i < 6; i++) run_packet(0, 1 + ($urandom % 3), 0, 0, "R2");
      idle("R9");
      // R3: random leading bits must not matter
      for (int i = 0; i < 20; i++) run_packet(0, 2 + ($urandom % 6), 0, 0, "R3");
      // R5: generate mode with gaps
      for (int i = 0; i < 15; i++) run_packet(0, 1 + ($urandom % 16), 0, 1, "R5");
      // R6: check mode, correct and corrupted CRCs
      for (int n = 1; n <= 11; n++) run_packet(1, n, 0, 1, "R6");
      for (int n = 1; n <= 11; n++) run_packet(1, n, 1, 0, "R6");
      for (int i = 0; i < 20; i++) run_packet(1, 1 + ($urandom % 14), $urandom % 2, 1, "R6");
      // mixed modes back to back
      for (int i = 0; i < 20; i++) run_packet($urandom % 2, 1 + ($urandom % 9), $urandom % 2, 0, "R5");
      repeat (3) idle("R9");
      // R8: reset in the middle of traffic
      run_packet(0, 5, 0, 0, "R1");
      do_reset();
      run_packet(1, 6, 0, 0, "R6");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule